// File: doc/BRIEF.md
# Per-Instruction Stride Prefetcher

This block watches a stream of memory accesses, each tagged with the address of the instruction that made it. A small direct-mapped table keyed by that instruction address keeps one entry per instruction: its tag, the last data address it touched, the last stride it showed and a saturating confidence count. Each access computes a new stride against the stored address. A repeated stride raises the confidence. A changed stride replaces the stored stride and clears the confidence. Because each instruction has its own entry, a regular walk is still recognised when accesses from other instructions are mixed in between.

Once the same nonzero stride has been confirmed often enough that the updated count exceeds a programmable threshold, the block starts a burst of prefetch requests. The burst covers the current address plus one, two, and so on up to a programmable degree times the stride. It issues one request per cycle, starting in the cycle after the access. There is no back-pressure. A new confirmed access replaces any burst still in progress.

Top module: `stride_prefetch`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `pf_valid` is low. Reset clears every table entry, so the first access from any instruction never starts a burst.
- R2: An entry is selected by the low IDX_W bits of `acc_pc` and is tagged by the remaining upper bits. An access whose selected entry is empty or holds another tag is a miss. A miss never prefetches and rewrites the entry with the new tag and address, a stride of zero and a count of zero.
- R3: On a hit, the stride is `acc_addr` minus the stored address, modulo 2^ADDR_W. If it equals the stored stride, the count rises by one and holds at 2^CNT_W-1. Otherwise the new stride is stored and the count becomes zero.
- R4: A hit starts a burst only when its stride matches the stored stride and the updated count is strictly greater than `cfg_thresh`.
- R5: A stride of zero never starts a burst, whatever the count.
- R6: A burst presents `acc_addr + k*stride` for k = 1 to D, one value per cycle, with k = 1 in the cycle after the access. D is `cfg_degree`, clamped to MAX_DEG. A degree of 0 starts no burst.
- R7: An access that starts a burst drops the rest of any burst in progress. An access that does not start a burst leaves a running burst untouched.
- R8: Instructions that map to different entries train independently, even when their accesses alternate cycle by cycle.
- R9: All prefetch addresses wrap modulo 2^ADDR_W, so negative strides run downward through address zero.
- R10: With no access and no burst in progress, `pf_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_pc | input | PC_W | Address of the instruction making the access |
| acc_addr | input | ADDR_W | Data address of the access |
| cfg_thresh | input | CNT_W | Confidence the updated count must exceed |
| cfg_degree | input | $clog2(MAX_DEG+1) | Number of strides to run ahead; clamped to MAX_DEG |
| pf_valid | output | 1 | A prefetch request is presented |
| pf_addr | output | ADDR_W | Prefetch address |

## Verification
The bench builds the block with IDX_W = 2, so the table has only four entries. This lets two instruction addresses collide on one entry after a few accesses. CNT_W stays at 2, so the count reaches saturation after three matching strides, and a threshold of 2 shows whether the count holds or wraps. MAX_DEG is 4, so a requested degree of 7 exercises the clamp. The 32-bit address width lets a downward walk cross address zero.

// File: rtl/stride_prefetch.sv
module stride_prefetch #(
  parameter int PC_W    = 32,
  parameter int ADDR_W  = 32,
  parameter int IDX_W   = 4,
  parameter int CNT_W   = 2,
  parameter int MAX_DEG = 4,
  localparam int DEG_W  = $clog2(MAX_DEG + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [PC_W-1:0]   acc_pc,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [CNT_W-1:0]  cfg_thresh,
  input  logic [DEG_W-1:0]  cfg_degree,
  output logic              pf_valid,
  output logic [ADDR_W-1:0] pf_addr
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int TAG_W   = PC_W - IDX_W;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [TAG_W-1:0]  tag_q  [ENTRIES];
  logic [ADDR_W-1:0] last_q [ENTRIES];
  logic [ADDR_W-1:0] strd_q [ENTRIES];
  logic [CNT_W-1:0]  cnt_q  [ENTRIES];
  logic [ENTRIES-1:0] vld_q;

  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic              hit, same, fire;
  logic [ADDR_W-1:0] new_strd, strd_nxt;
  logic [CNT_W-1:0]  cnt_nxt;
  logic [DEG_W-1:0]  deg_eff;

  logic [ADDR_W-1:0] iss_addr, iss_strd;
  logic [DEG_W-1:0]  iss_left;

  assign idx      = acc_pc[IDX_W-1:0];
  assign tag      = acc_pc[PC_W-1:IDX_W];
  assign hit      = vld_q[idx] && (tag_q[idx] == tag);
  assign new_strd = acc_addr - last_q[idx];
  assign same     = hit && (new_strd == strd_q[idx]);
  assign strd_nxt = hit ? new_strd : '0;
  assign deg_eff  = (cfg_degree > DEG_W'(MAX_DEG)) ? DEG_W'(MAX_DEG) : cfg_degree;

  always_comb begin
    cnt_nxt = '0;
    if (same) cnt_nxt = (cnt_q[idx] == CNT_MAX) ? CNT_MAX : cnt_q[idx] + 1'b1;
  end

  assign fire = acc_valid && same && (new_strd != '0) &&
                (cnt_nxt > cfg_thresh) && (deg_eff != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         vld_q <= '0;
    else if (acc_valid) vld_q[idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (acc_valid) begin
      tag_q[idx]  <= tag;
      last_q[idx] <= acc_addr;
      strd_q[idx] <= strd_nxt;
      cnt_q[idx]  <= cnt_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iss_addr <= '0;
      iss_strd <= '0;
      iss_left <= '0;
    end else if (fire) begin
      iss_addr <= acc_addr + new_strd;
      iss_strd <= new_strd;
      iss_left <= deg_eff;
    end else if (iss_left != '0) begin
      iss_addr <= iss_addr + iss_strd;
      iss_left <= iss_left - 1'b1;
    end
  end

  assign pf_valid = (iss_left != '0);
  assign pf_addr  = iss_addr;
endmodule

// File: rtl/stride_prefetch_chk.sv
module stride_prefetch_chk #(
  parameter int ADDR_W  = 32,
  parameter int MAX_DEG = 4,
  localparam int DEG_W  = $clog2(MAX_DEG + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic [DEG_W-1:0]  cfg_degree,
  input logic              pf_valid,
  input logic [ADDR_W-1:0] pf_addr
);
  logic [DEG_W:0] since;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         since <= (DEG_W+1)'(MAX_DEG + 1);
    else if (acc_valid)                 since <= (DEG_W+1)'(1);
    else if (since <= (DEG_W+1)'(MAX_DEG)) since <= since + 1'b1;
  end

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pf_valid && !acc_valid |=> !pf_valid);

  // R6
  burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> (since != '0) && (since <= (DEG_W+1)'(MAX_DEG)));

  // R6
  even_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid && $past(pf_valid) && $past(pf_valid, 2) && !$past(acc_valid) && !$past(acc_valid, 2)
    |-> (pf_addr - $past(pf_addr)) == ($past(pf_addr) - $past(pf_addr, 2)));

  // R6
  zero_deg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_degree == '0) && !pf_valid |=> !pf_valid);
endmodule

bind stride_prefetch stride_prefetch_chk #(.ADDR_W(ADDR_W), .MAX_DEG(MAX_DEG)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .cfg_degree(cfg_degree),
  .pf_valid(pf_valid), .pf_addr(pf_addr)
);

// File: tb/stride_prefetch_bench.sv
`timescale 1ns/1ps
module stride_prefetch_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_pc = '0;
  logic [31:0] acc_addr = '0;
  logic [1:0]  cfg_thresh = 2'd1;
  logic [2:0]  cfg_degree = 3'd2;
  logic        pf_valid;
  logic [31:0] pf_addr;

  int compared = 0, mismatched = 0;
  string phase = "R1";

  logic [29:0] m_tag [4];
  logic [31:0] m_last [4];
  logic [31:0] m_strd [4];
  int          m_cnt [4];
  bit          m_vld [4];
  logic [31:0] q [$];

  always #10 clk = ~clk;

  stride_prefetch #(.PC_W(32), .ADDR_W(32), .IDX_W(2), .CNT_W(2), .MAX_DEG(4)) u_stride_prefetch (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_pc(acc_pc), .acc_addr(acc_addr),
    .cfg_thresh(cfg_thresh), .cfg_degree(cfg_degree), .pf_valid(pf_valid), .pf_addr(pf_addr)
  );

  task automatic model_step();
    int i, c, d;
    bit hit, match;
    logic [31:0] s;
    if (q.size() != 0) void'(q.pop_front());
    if (acc_valid) begin
      i = int'(acc_pc[1:0]);
      hit = m_vld[i] && (m_tag[i] == acc_pc[31:2]);
      s = acc_addr - m_last[i];
      match = hit && (s == m_strd[i]);
      c = match ? ((m_cnt[i] == 3) ? 3 : m_cnt[i] + 1) : 0;
      d = (cfg_degree > 3'd4) ? 4 : int'(cfg_degree);
      if (match && s != 0 && c > int'(cfg_thresh) && d > 0) begin
        q.delete();
        for (int k = 1; k <= d; k++) q.push_back(acc_addr + 32'(k) * s);
      end
      m_vld[i] = 1'b1;
      m_tag[i] = acc_pc[31:2];
      m_last[i] = acc_addr;
      m_strd[i] = hit ? s : 32'd0;
      m_cnt[i] = c;
    end
  endtask

  task automatic compare();
    bit ev;
    logic [31:0] ea;
    ev = (q.size() != 0);
    ea = ev ? q[0] : 32'd0;
    compared++;
    if (pf_valid !== ev || (ev && pf_addr !== ea)) begin
      mismatched++;
      $display("FAIL %s: pf_valid=%0b pf_addr=%h expected pf_valid=%0b pf_addr=%h",
               phase, pf_valid, pf_addr, ev, ea);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic acc(input logic [31:0] pc, input logic [31:0] a);
    acc_valid = 1'b1; acc_pc = pc; acc_addr = a;
    cycle();
    acc_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int j = 0; j < n; j++) cycle();
  endtask

  initial begin
    #4_000_000;
    mismatched++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin m_vld[i] = 0; m_cnt[i] = 0; m_last[i] = 0; m_strd[i] = 0; m_tag[i] = 0; end
    // R1: reset state
    repeat (3) @(negedge clk);
    compare();
    rst_n = 1'b1;
    idle(1);
    acc(32'h0000_0400, 32'h1000);
    // R3 R4: train to threshold 1
    phase = "R4";
    acc(32'h0000_0400, 32'h1040);
    acc(32'h0000_0400, 32'h1080);
    acc(32'h0000_0400, 32'h10C0);
    idle(4);
    // R6: degree 3, degree 0, clamped degree 7
    phase = "R6";
    cfg_degree = 3'd3; acc(32'h0000_0400, 32'h1100); idle(4);
    cfg_degree = 3'd0; acc(32'h0000_0400, 32'h1140); idle(3);
    cfg_degree = 3'd7; acc(32'h0000_0400, 32'h1180); idle(6);
    // R3: saturation with threshold 2
    phase = "R3";
    cfg_thresh = 2'd2; cfg_degree = 3'd1;
    for (int j = 0; j < 4; j++) begin acc(32'h0000_0400, 32'h11C0 + 32'(j) * 32'h40); idle(1); end
    acc(32'h0000_0400, 32'h9000); idle(2);
    acc(32'h0000_0400, 32'h9040); idle(2);
    // R5: zero stride
    phase = "R5";
    cfg_thresh = 2'd0; cfg_degree = 3'd2;
    for (int j = 0; j < 5; j++) acc(32'h0000_0501, 32'h2000);
    idle(3);
    // R8: interleaved instructions
    phase = "R8";
    cfg_thresh = 2'd1;
    for (int j = 0; j < 5; j++) begin
      acc(32'h0000_0602, 32'h3000 + 32'(j) * 32'h10);
      acc(32'h0000_0703, 32'h8000 - 32'(j) * 32'h20);
    end
    idle(4);
    // R9: downward walk through zero
    phase = "R9";
    cfg_degree = 3'd3;
    acc(32'h0000_0501, 32'h30); acc(32'h0000_0501, 32'h20);
    acc(32'h0000_0501, 32'h10); acc(32'h0000_0501, 32'h0);
    idle(4);
    // R2: aliasing on entry 2
    phase = "R2";
    acc(32'h0000_0902, 32'h3050);
    acc(32'h0000_0602, 32'h3060);
    acc(32'h0000_0602, 32'h3070);
    acc(32'h0000_0602, 32'h3080);
    idle(4);
    // R7: burst interrupted by non-qualifying then qualifying access
    phase = "R7";
    cfg_degree = 3'd4;
    acc(32'h0000_0602, 32'h3090);
    idle(1);
    acc(32'h0000_0A01, 32'h7777);
    idle(1);
    acc(32'h0000_0602, 32'h30A0);
    idle(6);
    // R10: idle stays idle
    phase = "R10";
    idle(5);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule